// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block turns the buffer status of a small UART into two interrupt requests for the processor. It holds two status flags: one says the transmit buffer is empty, the other says the receive buffer holds a byte. It also holds one enable bit per direction. Each request is a plain level: the flag ANDed with its enable. No acknowledge input exists. Software removes a request in one of two ways: it does the buffer access that clears the flag, or it clears the enable bit.

The block watches the processor bus. A write to the transmit buffer address clears the empty flag. A read of the receive buffer address clears the full flag. A write to the control address loads the two enable bits. Two strobes set the flags: one comes from the transmit shifter when it takes the byte out of the buffer, and one comes from the receiver when a frame completes. When a clearing access and a setting strobe land in the same cycle, the setting strobe wins.

Each request has its own fixed vector. The two vectors are two bytes apart and cover addresses 0xEC to 0xEF. A combined vector output shows the receive vector when both requests are active.

Top module: `uart_irq_gen`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, both enables are 0, tx_irq, rx_irq and irq_any are 0, and irq_vec is 0x00.
- R2: tx_irq equals tx_empty AND the transmit enable, and rx_irq equals rx_full AND the receive enable. Both follow the state registered at the preceding clock edge.
- R3: A bus write to address 0x11 (the transmit buffer) clears tx_empty at that clock edge, and so removes tx_irq.
- R4: A bus read of address 0x12 (the receive buffer) clears rx_full at that clock edge, and so removes rx_irq.
- R5: A pulse on tx_load_done sets tx_empty. A pulse on rx_done sets rx_full.
- R6: If tx_load_done comes in the same cycle as a transmit buffer write, tx_empty ends up 1. If rx_done comes in the same cycle as a receive buffer read, rx_full ends up 1.
- R7: A bus write to address 0x10 loads the enables. bus_wdata bit 0 is the transmit enable and bit 1 is the receive enable. Writing 0 to an enable removes its request while the flag stays set.
- R8: irq_vec is 0xEC while rx_irq is 1. It is 0xEE while only tx_irq is 1, and 0x00 while neither is 1. irq_any is the OR of both requests.
- R9: A request is never cleared by anything except its own buffer access or its enable. A read of 0x11, a write of 0x12, and accesses to any other address leave both flags and both enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Bus register address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 2 | Low write-data bits that carry the enables |
| tx_load_done | input | 1 | Transmit shifter has taken the buffer byte |
| rx_done | input | 1 | Receiver has completed a frame |
| tx_empty | output | 1 | Transmit buffer empty flag |
| rx_full | output | 1 | Receive buffer full flag |
| tx_irq | output | 1 | Transmit interrupt request (level) |
| rx_irq | output | 1 | Receive interrupt request (level) |
| irq_any | output | 1 | Either request active |
| irq_vec | output | 8 | Vector of the winning request, 0 when none |

## Verification
The bench drives each setting strobe in the same cycle as the matching buffer access. A design that lets the access win loses a completed byte and leaves the request silent. It also sends the wrong access type to each buffer address: a read of the transmit address and a write of the receive address. A design that decodes the address without the direction then drops a pending request. Both requests are raised together to check that the receive vector wins and that disabling the receive side hands the vector to the transmit side. Random bus traffic, compared against a bench model, checks that no request ever falls except through its own access or its enable.

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int          ADDR_W     = 8,
  parameter int          VEC_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] TXBUF_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] RXBUF_ADDR = 8'h12,
  parameter logic [VEC_W-1:0]  RX_VECTOR  = 8'hEC,
  parameter logic [VEC_W-1:0]  TX_VECTOR  = 8'hEE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_wdata,
  input  logic              tx_load_done,
  input  logic              rx_done,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              irq_any,
  output logic [VEC_W-1:0]  irq_vec
);

  localparam int TX_EN = 0;
  localparam int RX_EN = 1;

  logic [1:0] en_q;
  logic       ctrl_wr, txbuf_wr, rxbuf_rd;

  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
  assign txbuf_wr = bus_wr && (bus_addr == TXBUF_ADDR);
  assign rxbuf_rd = bus_rd && (bus_addr == RXBUF_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata;
      if (tx_load_done)  tx_empty <= 1'b1;
      else if (txbuf_wr) tx_empty <= 1'b0;
      if (rx_done)       rx_full  <= 1'b1;
      else if (rxbuf_rd) rx_full  <= 1'b0;
    end
  end

  assign tx_irq  = tx_empty & en_q[TX_EN];
  assign rx_irq  = rx_full  & en_q[RX_EN];
  assign irq_any = tx_irq | rx_irq;
  assign irq_vec = rx_irq ? RX_VECTOR : (tx_irq ? TX_VECTOR : '0);

  a_r3_txwrite_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (txbuf_wr && !tx_load_done) |=> !tx_empty && !tx_irq);

  a_r4_rxread_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rxbuf_rd && !rx_done) |=> !rx_full && !rx_irq);

  a_r6_tx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_done |=> tx_empty);

  a_r6_rx_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full);

  a_r8_rx_priority: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (irq_vec == RX_VECTOR) && irq_any);

  a_r9_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && !txbuf_wr && !ctrl_wr) |=> tx_irq);

  a_r9_rx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !rxbuf_rd && !ctrl_wr) |=> rx_irq);

endmodule

// File: tb/uart_irq_gen_bench.sv
`timescale 1ns/1ps
module uart_irq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_wdata = '0;
  logic       tx_load_done = 1'b0, rx_done = 1'b0;
  logic       tx_empty, rx_full, tx_irq, rx_irq, irq_any;
  logic [7:0] irq_vec;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic       m_tx, m_rx;
  logic [1:0] m_en;

  always #2 clk = ~clk;

  uart_irq_gen u_uart_irq_gen (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tx_load_done(tx_load_done),
    .rx_done(rx_done), .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .irq_any(irq_any), .irq_vec(irq_vec)
  );

  function automatic logic [7:0] exp_vec(logic t, logic r, logic [1:0] e);
    if (r && e[1]) return 8'hEC;
    if (t && e[0]) return 8'hEE;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3/R5 tx_empty", tx_empty, m_tx);
    chk("R4/R5 rx_full", rx_full, m_rx);
    chk("R2 tx_irq", tx_irq, m_tx & m_en[0]);
    chk("R2 rx_irq", rx_irq, m_rx & m_en[1]);
    chk("R8 irq_any", irq_any, (m_tx & m_en[0]) | (m_rx & m_en[1]));
    chk("R8 irq_vec", irq_vec, exp_vec(m_tx, m_rx, m_en));
  endtask

  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [1:0] d, input logic txd, input logic rxd);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    tx_load_done = txd; rx_done = rxd;
    @(posedge clk);
    if (wr && a == 8'h10) m_en = d;
    if (txd) m_tx = 1'b1; else if (wr && a == 8'h11) m_tx = 1'b0;
    if (rxd) m_rx = 1'b1; else if (rd && a == 8'h12) m_rx = 1'b0;
    #1;
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    m_tx = 1'b1; m_rx = 1'b0; m_en = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tx_empty", tx_empty, 1'b1);
    chk("R1 rx_full", rx_full, 1'b0);
    chk("R1 irq_any", irq_any, 1'b0);
    chk("R1 irq_vec", irq_vec, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R7: enable tx only, then rx only, then clear tx enable
    step(1, 0, 8'h10, 2'b01, 0, 0);
    chk("R7 tx_irq on", tx_irq, 1'b1);
    step(0, 0, 8'h00, 2'b00, 0, 1);
    step(1, 0, 8'h10, 2'b10, 0, 0);
    chk("R7 tx dropped by enable", tx_irq, 1'b0);
    chk("R7 flag kept", tx_empty, 1'b1);
    // R8: both pending, rx wins; then disable rx, tx vector shows
    step(1, 0, 8'h10, 2'b11, 0, 0);
    chk("R8 both -> EC", irq_vec, 8'hEC);
    step(1, 0, 8'h10, 2'b01, 0, 0);
    chk("R8 tx only -> EE", irq_vec, 8'hEE);
    // R9: wrong direction accesses are ignored
    step(1, 0, 8'h10, 2'b11, 0, 0);
    step(0, 1, 8'h11, 2'b00, 0, 0);
    chk("R9 read of txbuf ignored", tx_irq, 1'b1);
    step(1, 0, 8'h12, 2'b00, 0, 0);
    chk("R9 write of rxbuf ignored", rx_irq, 1'b1);
    step(1, 1, 8'h33, 2'b00, 0, 0);
    chk("R9 other address ignored", irq_any, 1'b1);
    // R6: set strobe wins over clearing access
    step(1, 0, 8'h11, 2'b00, 1, 0);
    chk("R6 tx set wins", tx_empty, 1'b1);
    step(0, 1, 8'h12, 2'b00, 0, 1);
    chk("R6 rx set wins", rx_full, 1'b1);
    // R3/R4: plain clearing accesses
    step(1, 0, 8'h11, 2'b00, 0, 0);
    chk("R3 tx write clears", tx_irq, 1'b0);
    step(0, 1, 8'h12, 2'b00, 0, 0);
    chk("R4 rx read clears", rx_irq, 1'b0);
    // R5: strobes set flags
    step(0, 0, 8'h00, 2'b00, 1, 1);
    chk("R5 both set", {tx_empty, rx_full}, 2'b11);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [1:0] r;
      r = 2'($urandom_range(0, 3));
      a = (r == 2'd3) ? 8'($urandom) : 8'h10 + {6'd0, r};
      step(($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0), a,
           2'($urandom), ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule